// File: doc/BRIEF.md
# Multi-IO Serial Flash Read Responder

This block is the device side of a serial flash that answers continuous array reads. The host sends an 8-bit command, three address bytes and one dummy byte, one bit per clock on data line 0. The block then streams bytes from its internal array for as long as chip select stays low. It drives two bits per clock for the dual command and four bits per clock for the quad command. The data lines are modelled as a value bus plus a per-line output enable, so the pad ring outside the block builds the bidirectional pins.

The array is a parameterized number of pages. Its content is a fixed function of the byte index. Two addressing schemes are supported, selected by a configuration input:
- Page mode uses 528-byte pages with separate page and byte fields.
- Binary mode treats the address as one linear value over 512-byte pages.

In both schemes the stream crosses page ends and the array end without gap clocks. A quad-enable configuration bit gates the quad command.

Top module: `mio_flash_reader`

## Requirements
- R1: The first 8 rising edges after chip select falls sample the command on dataIn, most significant bit first. The next 24 sample the address and the next 8 sample a dummy byte. No line is enabled during these 40 clocks. The first data slice is driven on the falling edge that follows the 40th rising edge, and each later slice changes only on a falling edge.
- R2: Command 3Bh streams two bits per clock on ioOut[1:0], with ioOe = 0011. Bits 7 and 6 of a byte come first, bit 7 on line 1, then 5/4, 3/2 and 1/0. Each byte takes four clocks.
- R3: Command 6Bh with quadEnable = 1 streams four bits per clock, with ioOe = 1111. Bits 7..4 go on lines 3..0 in the first clock and bits 3..0 in the second, so each byte takes two clocks.
- R4: Command 6Bh with quadEnable = 0 is ignored. ioOe stays 0000 until chip select rises.
- R5: Any command other than 3Bh and 6Bh (for example 0Bh) leaves every line disabled until chip select rises.
- R6: In page mode (binaryMode = 0), the page is address bits [22:10] taken modulo PAGE_COUNT and the start offset is bits [9:0]. An offset of 528 or more is reduced by 528. The byte index is page*528 + offset.
- R7: In binary mode (binaryMode = 1), the byte index is the address taken modulo PAGE_COUNT*512. It splits into page = index/512 and offset = index%512.
- R8: After the last offset of a page (527 in page mode, 511 in binary mode), the next byte is offset 0 of the following page, with no gap clock.
- R9: After the last byte of the last page, the next byte is offset 0 of page 0, with no gap clock.
- R10: While chip select is high, all enables are 0. A rising chip select ends the read at once, even in the middle of a byte, and the next falling edge starts a fresh command.
- R11: The byte at index i is (29*i + floor(i/256) + 60) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock; inputs sampled on the rising edge, outputs change on the falling edge |
| csN | input | 1 | Active-low chip select; high clears the whole session asynchronously |
| dataIn | input | 1 | Serial command, address and dummy bits (data line 0 as input) |
| quadEnable | input | 1 | Configuration bit that permits the quad command |
| binaryMode | input | 1 | 1 selects 512-byte linear addressing, 0 selects 528-byte page addressing |
| ioOut | output | 4 | Output values for data lines 3..0 |
| ioOe | output | 4 | Per-line output enables for data lines 3..0 |

## Verification
Two of the block's functions can fall in the same clock: the byte-boundary step that fetches the next byte, and the page roll or array wrap. On the last page these combine with the array wrap into a single step. The bench provokes this by starting reads a few bytes before offset 527 or 511 on the last page, in both addressing modes and at both lane widths. A separate start inside a page at offset 510 confirms that no roll happens at the 512 mark in page mode. A behavioural model builds the expected slice for every clock from the page/offset rules, and the enabled lines are compared against it on each rising edge. A chip-select rise in the middle of a byte is judged by the enables dropping before the next clock and by a clean restart afterwards.

// File: rtl/mio_flash_pkg.sv
package mio_flash_pkg;

  localparam int CMD_BITS   = 8;
  localparam int ADDR_BITS  = 24;
  localparam int DUMMY_BITS = 8;

  localparam logic [7:0] OP_DUAL_READ = 8'h3B;
  localparam logic [7:0] OP_QUAD_READ = 8'h6B;

  // strobes from control to datapath
  typedef struct packed {
    logic captureAddr;
    logic streamOn;
    logic quadSel;
  } strobe_t;

  // fixed array content as a function of the linear byte index
  function automatic logic [7:0] memByte(input logic [23:0] idx);
    return 8'(idx * 24'd29 + (idx >> 8) + 24'h3C);
  endfunction

endpackage

// File: rtl/mio_flash_ctrl.sv
module mio_flash_ctrl
  import mio_flash_pkg::*;
(
  input  logic    sck,
  input  logic    csN,
  input  logic    dataIn,
  input  logic    quadEnable,
  output strobe_t strb
);

  localparam int OPC_END   = CMD_BITS - 1;
  localparam int ADDR_END  = CMD_BITS + ADDR_BITS - 1;
  localparam int DUMMY_END = CMD_BITS + ADDR_BITS + DUMMY_BITS - 1;
  localparam int CNT_W     = $clog2(DUMMY_END + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(DUMMY_END + 1);

  typedef enum logic [2:0] {ST_OPC, ST_ADDR, ST_DUMMY, ST_STREAM, ST_IGNORE} state_t;

  state_t           state;
  logic [CNT_W-1:0] bitCnt;
  logic [CMD_BITS-2:0] opShift;
  logic [CMD_BITS-1:0] opcodeNow;
  logic             quadSel;

  assign opcodeNow = {opShift, dataIn};

  always_ff @(posedge sck or posedge csN) begin
    if (csN) begin
      state   <= ST_OPC;
      bitCnt  <= '0;
      opShift <= '0;
      quadSel <= 1'b0;
    end else begin
      if (bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
      case (state)
        ST_OPC: begin
          opShift <= {opShift[CMD_BITS-3:0], dataIn};
          if (bitCnt == CNT_W'(OPC_END)) begin
            if (opcodeNow == OP_DUAL_READ) begin
              state   <= ST_ADDR;
              quadSel <= 1'b0;
            end else if (opcodeNow == OP_QUAD_READ && quadEnable) begin
              state   <= ST_ADDR;
              quadSel <= 1'b1;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ADDR:  if (bitCnt == CNT_W'(ADDR_END))  state <= ST_DUMMY;
        ST_DUMMY: if (bitCnt == CNT_W'(DUMMY_END)) state <= ST_STREAM;
        default:  state <= state;
      endcase
    end
  end

  assign strb.captureAddr = (state == ST_ADDR);
  assign strb.streamOn    = (state == ST_STREAM);
  assign strb.quadSel     = quadSel;

  AST_STREAM_AFTER_DUMMY: assert property (@(posedge sck) disable iff (csN)
    strb.streamOn |-> (bitCnt == CNT_SAT)) else $error("stream before dummy end"); // R1

  AST_QUAD_GATED: assert property (@(posedge sck) disable iff (csN)
    ($past(state) == ST_OPC && state == ST_ADDR && quadSel) |-> $past(quadEnable))
    else $error("quad accepted without enable"); // R4

  AST_IGNORE_STICKY: assert property (@(posedge sck) disable iff (csN)
    (state == ST_IGNORE) |=> (state == ST_IGNORE)) else $error("ignored command resumed"); // R5

endmodule

// File: rtl/mio_flash_datapath.sv
module mio_flash_datapath
  import mio_flash_pkg::*;
#(
  parameter int PAGE_COUNT = 4
) (
  input  logic       sck,
  input  logic       csN,
  input  logic       dataIn,
  input  logic       binaryMode,
  input  strobe_t    strb,
  output logic [3:0] ioOut,
  output logic [3:0] ioOe
);

  localparam int PAGE_BITS = $clog2(PAGE_COUNT);
  localparam int SR_W      = 10 + PAGE_BITS;
  localparam logic [9:0] PAGE_528   = 10'd528;
  localparam logic [9:0] LAST_528   = 10'd527;
  localparam logic [9:0] LAST_BIN   = 10'd511;

  // only the low address bits that can select a byte are kept
  logic [SR_W-1:0] addrSr;

  always_ff @(posedge sck or posedge csN) begin
    if (csN) addrSr <= '0;
    else if (strb.captureAddr) addrSr <= {addrSr[SR_W-2:0], dataIn};
  end

  logic [PAGE_BITS-1:0] startPage, ptrPage, curPage, nextPage;
  logic [9:0]  rawOff, startOff, ptrOff, curOff, nextOff, lastOff;
  logic [1:0]  phase, curPh, lastPh;
  logic        started;
  logic [23:0] curIdx;
  logic [7:0]  curByte;
  logic [3:0]  slice, outReg;

  always_comb begin
    lastOff = binaryMode ? LAST_BIN : LAST_528;
    rawOff  = addrSr[9:0];
    if (binaryMode) begin
      startPage = addrSr[9 +: PAGE_BITS];
      startOff  = {1'b0, addrSr[8:0]};
    end else begin
      startPage = addrSr[10 +: PAGE_BITS];
      startOff  = (rawOff >= PAGE_528) ? rawOff - PAGE_528 : rawOff;
    end

    curPage = started ? ptrPage : startPage;
    curOff  = started ? ptrOff  : startOff;
    curPh   = started ? phase   : 2'd0;

    if (binaryMode) curIdx = 24'({curPage, curOff[8:0]});
    else            curIdx = 24'(curPage) * 24'd528 + 24'(curOff);
    curByte = memByte(curIdx);

    lastPh = strb.quadSel ? 2'd1 : 2'd3;
    if (strb.quadSel) begin
      slice = curPh[0] ? curByte[3:0] : curByte[7:4];
    end else begin
      case (curPh)
        2'd0:    slice = {2'b00, curByte[7:6]};
        2'd1:    slice = {2'b00, curByte[5:4]};
        2'd2:    slice = {2'b00, curByte[3:2]};
        default: slice = {2'b00, curByte[1:0]};
      endcase
    end

    if (curOff == lastOff) begin
      nextOff  = '0;
      nextPage = curPage + 1'b1;
    end else begin
      nextOff  = curOff + 1'b1;
      nextPage = curPage;
    end
  end

  always_ff @(negedge sck or posedge csN) begin
    if (csN) begin
      started <= 1'b0;
      outReg  <= '0;
      ptrPage <= '0;
      ptrOff  <= '0;
      phase   <= '0;
    end else if (strb.streamOn) begin
      started <= 1'b1;
      outReg  <= slice;
      if (curPh == lastPh) begin
        ptrPage <= nextPage;
        ptrOff  <= nextOff;
        phase   <= '0;
      end else begin
        ptrPage <= curPage;
        ptrOff  <= curOff;
        phase   <= curPh + 2'd1;
      end
    end
  end

  assign ioOut = outReg;
  assign ioOe  = started ? (strb.quadSel ? 4'hF : 4'h3) : 4'h0;

  AST_OFF_IN_PAGE: assert property (@(negedge sck) disable iff (csN)
    started |-> (ptrOff <= lastOff)) else $error("offset beyond page"); // R6

  AST_PAGE_ROLL: assert property (@(negedge sck) disable iff (csN)
    ($past(started) && $past(ptrOff) == lastOff && ptrOff != $past(ptrOff))
    |-> (ptrOff == '0 && ptrPage == PAGE_BITS'($past(ptrPage) + 1'b1)))
    else $error("bad page roll"); // R8

endmodule

// File: rtl/mio_flash_reader.sv
module mio_flash_reader
  import mio_flash_pkg::*;
#(
  parameter int PAGE_COUNT = 4  // power of two, at least 2
) (
  input  logic       sck,
  input  logic       csN,
  input  logic       dataIn,
  input  logic       quadEnable,
  input  logic       binaryMode,
  output logic [3:0] ioOut,
  output logic [3:0] ioOe
);

  strobe_t strb;

  mio_flash_ctrl u_ctrl (
    .sck        (sck),
    .csN        (csN),
    .dataIn     (dataIn),
    .quadEnable (quadEnable),
    .strb       (strb)
  );

  mio_flash_datapath #(.PAGE_COUNT(PAGE_COUNT)) u_datapath (
    .sck        (sck),
    .csN        (csN),
    .dataIn     (dataIn),
    .binaryMode (binaryMode),
    .strb       (strb),
    .ioOut      (ioOut),
    .ioOe       (ioOe)
  );

  AST_OE_PATTERN: assert property (@(posedge sck) disable iff (csN)
    (ioOe == 4'h0 || ioOe == 4'h3 || ioOe == 4'hF)) else $error("bad enable pattern"); // R2

  AST_OE_ONLY_STREAM: assert property (@(posedge sck) disable iff (csN)
    (ioOe != 4'h0) |-> strb.streamOn) else $error("lines driven outside stream"); // R1

endmodule

// File: tb/mio_flash_reader_test.sv
`timescale 1ns/1ps
module mio_flash_reader_test;

  localparam int PAGES = 4;

  logic sck = 1'b0;
  logic csN, dataIn, quadEnable, binaryMode;
  logic [3:0] ioOut, ioOe;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  mio_flash_reader #(.PAGE_COUNT(PAGES)) uut (
    .sck(sck), .csN(csN), .dataIn(dataIn), .quadEnable(quadEnable),
    .binaryMode(binaryMode), .ioOut(ioOut), .ioOe(ioOe)
  );

  always #2.5 sck = ~sck;

  function automatic int refByte(input int i);
    return (29 * i + i / 256 + 60) % 256;
  endfunction

  task automatic check(input string tag, input int cyc, input logic [3:0] expV, input logic [3:0] expO);
    checks++;
    if (ioOe !== expO || (ioOut & ioOe) !== (expV & expO)) begin
      failures++;
      $display("FAIL %s cycle %0d out=%h oe=%h expected out=%h oe=%h",
               tag, cyc, ioOut & ioOe, ioOe, expV & expO, expO);
    end
  endtask

  task automatic runCmd(input string tag, input logic [7:0] op, input logic [23:0] addr,
                        input logic qe, input logic bm, input int slices);
    logic [39:0] stream;
    logic [3:0] expV[$];
    logic [3:0] expO[$];
    bit accept, quad;
    int page, off, pageSize, idx, b;
    stream = {op, addr, 8'h00};
    quad   = (op == 8'h6B);
    accept = (op == 8'h3B) || (quad && qe);
    pageSize = bm ? 512 : 528;
    if (bm) begin
      idx  = int'(addr) % (PAGES * 512);
      page = idx / 512;
      off  = idx % 512;
    end else begin
      page = (int'(addr) >> 10) % PAGES;
      off  = int'(addr) & 1023;
      if (off >= 528) off -= 528;
    end
    for (int n = 0; n < slices / 2 + 2; n++) begin
      idx = page * pageSize + off;
      b   = refByte(idx);
      if (quad) begin
        expV.push_back(4'(b >> 4)); expO.push_back(4'hF);
        expV.push_back(4'(b));      expO.push_back(4'hF);
      end else begin
        for (int s = 3; s >= 0; s--) begin
          expV.push_back(4'((b >> (2 * s)) & 3)); expO.push_back(4'h3);
        end
      end
      off++;
      if (off == pageSize) begin
        off  = 0;
        page = (page + 1) % PAGES;
      end
    end
    quadEnable = qe;
    binaryMode = bm;
    for (int k = 0; k < 40 + slices; k++) begin
      @(negedge sck);
      #0.5;
      if (k == 0) csN = 1'b0;
      dataIn = (k < 40) ? stream[39 - k] : 1'(k);
      @(posedge sck);
      #1;
      if (k < 40 || !accept) check(tag, k, 4'h0, 4'h0);
      else check(tag, k, expV[k - 40], expO[k - 40]);
    end
    @(negedge sck);
    #0.5 csN = 1'b1;
    #0.5 check({tag, " R10 release"}, -1, 4'h0, 4'h0);
    @(posedge sck);
    #1 check({tag, " R10 idle"}, -1, 4'h0, 4'h0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    csN = 1'b0; dataIn = 1'b0; quadEnable = 1'b0; binaryMode = 1'b0;
    #1 csN = 1'b1;
    @(posedge sck);
    #1 check("R10 reset", 0, 4'h0, 4'h0);

    runCmd("R1 R2 R6 R11 dual page", 8'h3B, (24'd1 << 10) | 24'd5, 1'b0, 1'b0, 24);
    runCmd("R3 R8 quad page cross", 8'h6B, 24'd525, 1'b1, 1'b0, 16);
    runCmd("R6 R8 no roll at 512", 8'h3B, (24'd2 << 10) | 24'd510, 1'b0, 1'b0, 20);
    runCmd("R6 offset above 527", 8'h3B, (24'd1 << 10) | 24'd1000, 1'b0, 1'b0, 12);
    runCmd("R6 R9 quad array wrap", 8'h6B, (24'd7 << 10) | 24'd526, 1'b1, 1'b0, 12);
    runCmd("R7 R9 dual binary wrap", 8'h3B, 24'h0407FD, 1'b0, 1'b1, 24);
    runCmd("R7 R8 quad binary cross", 8'h6B, 24'h0001FE, 1'b1, 1'b1, 10);
    runCmd("R3 R7 R9 quad binary end", 8'h6B, 24'h3FFFFF, 1'b1, 1'b1, 8);
    runCmd("R4 quad disabled", 8'h6B, 24'h000010, 1'b0, 1'b0, 12);
    runCmd("R5 other opcode", 8'h0B, 24'h000010, 1'b1, 1'b0, 12);
    runCmd("R10 abort mid byte", 8'h3B, 24'd5, 1'b0, 1'b0, 3);
    runCmd("R10 R1 restart", 8'h3B, 24'd5, 1'b0, 1'b0, 8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule